// File: doc/BRIEF.md
# Configurable external interrupt forwarder

This block takes a bank of asynchronous external interrupt lines and turns each one into an active-high level request toward a downstream interrupt controller. Every line is first brought into the local clock domain and then watched by a detector that can be set, per line, to sense a level or a transition, and to treat either high or low (rising or falling) as the active sense. A detected condition sets a sticky request latch for that line.

A per-line hold bit keeps the forwarded output low without stopping the latch, so conditions that arrive while a line is held are not lost and show up on the output once the hold is lifted. Software reaches the hold, sense-type and polarity settings, the raw and held-off request status and a write-one-to-clear acknowledge word through a small word-addressed register port with single-cycle writes and registered reads.

Top module: `extirq_fwd`

## Requirements
- R1: After reset, every hold bit reads 1, every polarity and sense-type bit reads 0, every request latch is 0 and every `irq_o` bit is 0.
- R2: An input change passes through a two-stage synchronizer; a level driven just before clock edge N sets the request latch at edge N+2, so `irq_o` of an unheld line rises after edge N+2 and not before.
- R3: In level sense (sense-type bit 0), a line's latch is set on every cycle its synchronized input is at the active level; a clear written while the input is still active is overridden, and the latch stays set after the input goes inactive until cleared.
- R4: In edge sense (sense-type bit 1), a line's latch is set only on the selected transition of the synchronized input, a steady active level or the opposite transition sets nothing, and the latch stays set until cleared.
- R5: The polarity word is at byte offset 0x14; bit value 1 selects active-high level or rising edge, 0 selects active-low level or falling edge.
- R6: The sense-type word is at byte offset 0x18; bit value 1 selects edge sense and 0 selects level sense, and the word reads back as written.
- R7: The hold word is at byte offset 0x00; a 1 forces the line's `irq_o` bit to 0 while the line's request latch keeps capturing conditions.
- R8: Writing the acknowledge word at byte offset 0x10 clears each latch whose data bit is 1 (unless the line sets it again in that cycle); bits written as 0 leave their latches unchanged, and all ones clears every latch.
- R9: The raw status word at byte offset 0x0C returns the request latches; the pending word at 0x08 returns raw status AND NOT hold; `irq_o` equals the pending word.
- R10: Read data appears on `bus_rdata` one cycle after `bus_re` and holds until the next read; offsets 0x04, 0x10, 0x1C and any offset at or above 0x20 read as zero, and writes to 0x04 and 0x1C change nothing. Address bits [1:0] are ignored.
- R11: Every `irq_o` bit is an active-high level, whatever sense and polarity its input uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| line_i | input | NUM_LINES | Asynchronous external interrupt inputs |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_re | input | 1 | Register read strobe, data follows one cycle later |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_LINES | Active-high level requests to the downstream controller |

## Verification
The hardest situation to reach from the ports is the race between an acknowledge write and a detector that still sees its condition in the same cycle, because it depends on the exact cycle the synchronized input arrives. The stimulus therefore writes the acknowledge word while a level-sensed input is still held active and while an edge-sensed input sits at a steady active level, then moves the input and repeats, so both the override and the honoured clear occur. A behavioural per-line model advanced on every clock, including the reset-release delay, catches any cycle where the latch, output or read data drifts from the requirements.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Data width of the register port.
  localparam int unsigned REG_W      = 32;
  // Number of address bits that select a register word.
  localparam int unsigned WORD_IDX_W = 3;
  // Byte address bits below the word index.
  localparam int unsigned IDX_LO     = 2;
  localparam int unsigned IDX_HI     = IDX_LO + WORD_IDX_W - 1;

  // Register word index (byte offset / 4); decoding software depends on it.
  typedef enum logic [WORD_IDX_W-1:0] {
    WR_HOLD = 3'd0,
    WR_SRC  = 3'd1,
    WR_PEND = 3'd2,
    WR_RAW  = 3'd3,
    WR_ACK  = 3'd4,
    WR_POL  = 3'd5,
    WR_MODE = 3'd6,
    WR_SOFT = 3'd7
  } word_e;

endpackage

// File: rtl/extirq_rst_sync.sv
module extirq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [DEPTH-1:0][W-1:0] stg_q;
  logic [DEPTH-1:0][W-1:0] stg_d;

  assign stg_d[0] = d_i;

  genvar g;
  for (g = 1; g < DEPTH; g++) begin : g_stage
    assign stg_d[g] = stg_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] edge_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic [NUM_LINES-1:0] raw_o,
  output logic [NUM_LINES-1:0] irq_o
);

  logic [NUM_LINES-1:0] prev_q, prev_d;
  logic [NUM_LINES-1:0] req_q, req_d;
  logic [NUM_LINES-1:0] act_now, act_before, set_w;

  // Active when the synchronized value equals the polarity bit.
  assign act_now    = ~(sync_i ^ pol_i);
  assign act_before = ~(prev_q ^ pol_i);
  // Level lines fire while active; edge lines only when newly active.
  assign set_w      = act_now & ~(edge_i & act_before);

  always_comb begin
    prev_d = sync_i;
    req_d  = (req_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= prev_d;
      req_q  <= req_d;
    end
  end

  assign raw_o = req_q;
  assign irq_o = req_q & ~mask_i;

  // Level lines with an active input must show a request next cycle.
  logic [NUM_LINES-1:0] lvl_busy;
  assign lvl_busy = ~edge_i & ~(sync_i ^ pol_i);

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && (|lvl_busy)) |=> ((req_q & $past(lvl_busy)) == $past(lvl_busy))); // R3

  // Pending edge lines without a clear stay pending.
  logic [NUM_LINES-1:0] edge_keep;
  assign edge_keep = req_q & edge_i & ~clr_i;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && (|edge_keep)) |=> ((req_q & $past(edge_keep)) == $past(edge_keep))); // R4

  // A clear on an edge line with no transition empties the latch.
  logic [NUM_LINES-1:0] edge_gone;
  assign edge_gone = clr_i & edge_i & ~(sync_i ^ prev_q);

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && (|edge_gone)) |=> ((req_q & $past(edge_gone)) == '0)); // R8

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] clr_o,
  output logic [REG_W-1:0]     rdata_o
);

  logic  hit;
  word_e idx;
  logic  unused_lsb;

  assign hit        = (addr_i[ADDR_W-1:IDX_HI+1] == '0);
  assign idx        = word_e'(addr_i[IDX_HI:IDX_LO]);
  assign unused_lsb = ^addr_i[IDX_LO-1:0];

  logic wr_hold, wr_pol, wr_mode, wr_ack;
  assign wr_hold = we_i & hit & (idx == WR_HOLD);
  assign wr_pol  = we_i & hit & (idx == WR_POL);
  assign wr_mode = we_i & hit & (idx == WR_MODE);
  assign wr_ack  = we_i & hit & (idx == WR_ACK);

  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic [NUM_LINES-1:0] pol_q,  pol_d;
  logic [NUM_LINES-1:0] edg_q,  edg_d;
  logic [REG_W-1:0]     rd_q,   rd_d, rd_mux;

  // Next-state for the configuration words, each with its own enable.
  always_comb begin
    mask_d = mask_q;
    pol_d  = pol_q;
    edg_d  = edg_q;
    if (wr_hold) mask_d = wdata_i[NUM_LINES-1:0];
    if (wr_pol)  pol_d  = wdata_i[NUM_LINES-1:0];
    if (wr_mode) edg_d  = wdata_i[NUM_LINES-1:0];
  end

  // Read selection; holes and write-only words return zero.
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (idx)
        WR_HOLD: rd_mux[NUM_LINES-1:0] = mask_q;
        WR_PEND: rd_mux[NUM_LINES-1:0] = raw_i & ~mask_q;
        WR_RAW:  rd_mux[NUM_LINES-1:0] = raw_i;
        WR_POL:  rd_mux[NUM_LINES-1:0] = pol_q;
        WR_MODE: rd_mux[NUM_LINES-1:0] = edg_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_comb begin
    rd_d = re_i ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pol_q  <= '0;
      edg_q  <= '0;
      rd_q   <= '0;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
      edg_q  <= edg_d;
      rd_q   <= rd_d;
    end
  end

  assign clr_o   = wr_ack ? wdata_i[NUM_LINES-1:0] : '0;
  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign edge_o  = edg_q;
  assign rdata_o = rd_q;

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && re_i && (!hit || idx == WR_SRC || idx == WR_ACK || idx == WR_SOFT))
      |=> (rdata_o == '0)); // R10

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !re_i) |=> $stable(rdata_o)); // R10

endmodule

// File: rtl/extirq_fwd.sv
module extirq_fwd
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);

  logic                 rst_i;
  logic [NUM_LINES-1:0] line_s;
  logic [NUM_LINES-1:0] mask_w, pol_w, edge_w, clr_w, raw_w;

  extirq_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i)
  );

  extirq_sync #(
    .W     (NUM_LINES),
    .DEPTH (SYNC_DEPTH)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  extirq_detect #(
    .NUM_LINES (NUM_LINES)
  ) u_det (
    .clk    (clk),
    .rst_n  (rst_i),
    .sync_i (line_s),
    .pol_i  (pol_w),
    .edge_i (edge_w),
    .clr_i  (clr_w),
    .mask_i (mask_w),
    .raw_o  (raw_w),
    .irq_o  (irq_o)
  );

  extirq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_i),
    .we_i    (bus_we),
    .re_i    (bus_re),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .raw_i   (raw_w),
    .mask_o  (mask_w),
    .pol_o   (pol_w),
    .edge_o  (edge_w),
    .clr_o   (clr_w),
    .rdata_o (bus_rdata)
  );

  AST_HELD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    ((irq_o & mask_w) == '0)); // R7

  AST_OUT_HAS_LATCH: assert property (@(posedge clk) disable iff (!rst_i)
    ((irq_o & ~raw_w) == '0)); // R9

endmodule

// File: tb/sim_extirq_fwd.sv
module sim_extirq_fwd;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] line_i;
  logic        bus_we;
  logic        bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] irq_o;

  int checks;
  int errs;
  bit cmp_en;
  bit done;

  extirq_fwd u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_i),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_s1, m_s2, m_prev, m_req, m_mask, m_pol, m_edg, m_rd;
  int        m_wake;

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a >= 8'h20) return 32'h0;
    case (a[4:2])
      3'd0:    return m_mask;
      3'd2:    return m_req & ~m_mask;
      3'd3:    return m_req;
      3'd5:    return m_pol;
      3'd6:    return m_edg;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_req = 0;
    m_mask = '1; m_pol = 0; m_edg = 0; m_rd = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
      m_wake = 0;
    end else if (m_wake < 2) begin
      m_wake++;
    end else begin
      bit [31:0] nreq;
      for (int i = 0; i < 32; i++) begin
        bit act, was, fire, clr;
        act  = (m_s2[i] == m_pol[i]);
        was  = (m_prev[i] == m_pol[i]);
        fire = m_edg[i] ? (act && !was) : act;
        clr  = (bus_we && bus_addr[7:2] == 6'd4) ? bus_wdata[i] : 1'b0;
        nreq[i] = fire || (m_req[i] && !clr);
      end
      if (bus_re) m_rd = m_read(bus_addr);
      if (bus_we && bus_addr < 8'h20) begin
        case (bus_addr[4:2])
          3'd0: m_mask = bus_wdata;
          3'd5: m_pol  = bus_wdata;
          3'd6: m_edg  = bus_wdata;
          default: ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = line_i;
      m_req  = nreq;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R9 irq_o vs model", irq_o, m_req & ~m_mask);
      check("R10 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed stimulus ----------------
  initial begin
    logic [31:0] v;
    rst_n = 1'b0; line_i = '0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    @(negedge clk);
    cmp_en = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);

    // Reset state
    check("R1 irq_o after reset", irq_o, 32'h0);
    rd(8'h00, v); check("R1 hold word reset", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 polarity reset", v, 32'h0);
    rd(8'h18, v); check("R1 sense-type reset", v, 32'h0);
    // Inputs low with active-low level sense: latched though held
    rd(8'h0C, v); check("R7 latched while held", v, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R9 pending word all held", v, 32'h0);

    // All active-high, clear everything
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    cyc(1);
    rd(8'h0C, v); check("R8 all-ones clear", v, 32'h0);
    wr(8'h00, 32'h0);
    check("R9 unheld idle", irq_o, 32'h0);

    // Synchronizer latency on level line 3
    line_i[3] = 1'b1;
    cyc(2); check("R2 not before edge N+2", irq_o & 32'h8, 32'h0);
    cyc(1); check("R2 set at edge N+2", irq_o & 32'h8, 32'h8);

    // Level: clear overridden while active, sticky after
    wr(8'h10, 32'h8);
    check("R3 clear overridden while active", irq_o & 32'h8, 32'h8);
    line_i[3] = 1'b0;
    cyc(5); check("R3 level latch sticky", irq_o & 32'h8, 32'h8);
    wr(8'h10, 32'h8);
    check("R3 clear once inactive", irq_o & 32'h8, 32'h0);

    // Edge sense on line 5, rising
    wr(8'h18, 32'h20);
    line_i[5] = 1'b1;
    cyc(3); check("R4 rising edge sets", irq_o & 32'h20, 32'h20);
    wr(8'h10, 32'h20);
    check("R4 clear with steady level", irq_o & 32'h20, 32'h0);
    cyc(3); check("R4 steady level sets nothing", irq_o & 32'h20, 32'h0);
    line_i[5] = 1'b0;
    cyc(4); check("R4 opposite edge ignored", irq_o & 32'h20, 32'h0);

    // Falling edge on line 5
    wr(8'h14, ~32'h20);
    line_i[5] = 1'b1;
    cyc(4); check("R5 rising ignored when falling chosen", irq_o & 32'h20, 32'h0);
    line_i[5] = 1'b0;
    cyc(3); check("R5 falling edge sets", irq_o & 32'h20, 32'h20);

    // Clear with a zero bit leaves that latch
    wr(8'h10, ~32'h20);
    check("R8 zero bit keeps latch", irq_o, 32'h20);
    rd(8'h0C, v); check("R9 raw word", v, 32'h20);

    // Hold line 5, latch line 7 while held
    wr(8'h00, 32'hA0);
    check("R7 held output low", irq_o, 32'h0);
    rd(8'h0C, v); check("R7 raw kept while held", v, 32'h20);
    rd(8'h08, v); check("R9 pending excludes held", v, 32'h0);
    line_i[7] = 1'b1;
    cyc(4); check("R7 held line stays low", irq_o, 32'h0);
    rd(8'h0C, v); check("R7 latches while held", v, 32'hA0);
    wr(8'h00, 32'h0);
    check("R11 active-high outputs", irq_o, 32'hA0);

    // Holes and write-only words
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    check("R10 hole writes no effect", irq_o, 32'hA0);
    rd(8'h04, v); check("R10 offset 0x04 zero", v, 32'h0);
    rd(8'h1C, v); check("R10 offset 0x1C zero", v, 32'h0);
    rd(8'h10, v); check("R10 offset 0x10 zero", v, 32'h0);
    rd(8'h40, v); check("R10 unmapped zero", v, 32'h0);
    rd(8'h15, v); check("R10 low address bits ignored", v, ~32'h20);
    rd(8'h18, v); check("R6 sense-type readback", v, 32'h20);

    // Read latency
    rd(8'h40, v);
    bus_re = 1'b1; bus_addr = 8'h18;
    #1 check("R10 data not before edge", bus_rdata, 32'h0);
    @(negedge clk);
    bus_re = 1'b0;
    check("R10 data one cycle after strobe", bus_rdata, 32'h20);
    cyc(2);
    check("R10 data holds", bus_rdata, 32'h20);

    // Active-low level on line 9 (input already low)
    wr(8'h14, ~32'h220);
    cyc(1); check("R5 active-low level sets", irq_o, 32'h2A0);
    check("R6 level mode on line 9 output", irq_o & 32'h200, 32'h200);

    cyc(3);
    cmp_en = 1'b0;
    finish_run();
  end

endmodule